// File: doc/BRIEF.md
# Panel Command Bus Engine

This block lets host software talk to a smart display panel over a parallel, 8080-style command bus. Software places a word in the write-data register, with one bit marking it as a real write request and another bit choosing between a command (index) cycle and a data cycle. Software then writes a kick to the write-start register. For a read, software places a word in the read-setup register and kicks the read-start register; the captured panel data comes back in the low half of that same register.

Each transfer selects one of two panels through a select bit in the kick word. The transfer then runs through three timed phases. In the setup phase, chip select and the register-select line are driven. In the strobe phase, the active-low write or read strobe is held low. In the hold phase, chip select stays low after the strobe has risen. The length of each phase comes from a configuration input. A busy flag in the status register covers the whole transfer, and software polls it until it clears.

Top module: `lcd_cmd_engine`

## Requirements
- R1: After reset both chip selects and both strobes are high (inactive), the status busy bit (bit 1 at offset 4) reads 0, and the read-data register (offset 2) reads 0.
- R2: A write to offset 1 with bit 0 set starts a write transfer if the word held at offset 0 has bit 28 set. The busy bit reads 1 from the cycle after that kick for exactly setup+pulse+hold+3 cycles.
- R3: A write kick is ignored when bit 28 of the held write word is 0. No chip select or strobe moves and busy stays 0.
- R4: For the whole transfer, the register-select line equals bit 24 of the loaded word (1 = data, 0 = index). During a write, the panel data bus carries bits 15:0 of the word and its output enable is 1.
- R5: Chip select goes low in the cycle after the kick and stays low for setup+1 cycles before the strobe falls. The strobe then stays low for pulse+1 cycles. Chip select stays low for hold+1 cycles after the strobe rises.
- R6: Kick bit 1 = 1 routes the transfer to the secondary chip select, and kick bit 1 = 0 routes it to the main chip select. At most one chip select is ever low.
- R7: A write of bit 24 to offset 2 followed by a kick at offset 3 (bit 0 set) runs a read cycle. The read strobe pulses, the write strobe stays high, and the data-bus output enable stays 0.
- R8: The panel input data is captured on the clock edge where the read strobe rises. It is returned in bits 15:0 of offset 2, and bits 31:16 read 0.
- R9: A kick that arrives while busy is ignored. The running transfer keeps its length, its chip select and its register-select value.
- R10: The write and read strobes are never low together, and a strobe is only low while a chip select is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Register write enable |
| reg_addr | input | ADDR_W | Register word offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational on reg_addr) |
| cfg_setup | input | CNT_W | Setup phase length minus one, in cycles |
| cfg_pulse | input | CNT_W | Strobe-low length minus one, in cycles |
| cfg_hold | input | CNT_W | Hold phase length minus one, in cycles |
| pnl_cs_main_n | output | 1 | Main panel chip select, active low |
| pnl_cs_sub_n | output | 1 | Secondary panel chip select, active low |
| pnl_rs | output | 1 | Register select: 1 data, 0 index |
| pnl_wr_n | output | 1 | Write strobe, active low |
| pnl_rd_n | output | 1 | Read strobe, active low |
| pnl_dout | output | DATA_W | Data driven to the panel |
| pnl_dout_en | output | 1 | Output enable for pnl_dout |
| pnl_din | input | DATA_W | Data returned by the panel |

## Verification
The bench changes the panel input on every strobe-low cycle of a read. A design that sampled the data at the falling edge, or one cycle early, would return a different value than the one present when the strobe rises. Each phase is measured against its own configured count, including the all-zero setting. This catches an off-by-one that would stretch or drop a setup, strobe or hold cycle. A second kick is sent mid-transfer with the opposite panel select. An engine that restarted or re-routed would either lengthen the busy window or move the chip select. A kick with the valid bit clear must leave the bus quiet. A design that ignored the bit would produce an unexpected transfer.

// File: rtl/lcd_cmd_pkg.sv
package lcd_cmd_pkg;

    localparam int unsigned WORD_W    = 32;
    localparam int unsigned VALID_BIT = 28;
    localparam int unsigned RS_BIT    = 24;
    localparam int unsigned GO_BIT    = 0;
    localparam int unsigned SEL_BIT   = 1;
    localparam int unsigned BUSY_BIT  = 1;

    localparam int unsigned OFS_WDATA = 0;
    localparam int unsigned OFS_WKICK = 1;
    localparam int unsigned OFS_RDATA = 2;
    localparam int unsigned OFS_RKICK = 3;
    localparam int unsigned OFS_STAT  = 4;

    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,
        PH_SETUP = 2'd1,
        PH_PULSE = 2'd2,
        PH_HOLD  = 2'd3
    } phase_e;

endpackage

// File: rtl/lcd_cmd_regs.sv
module lcd_cmd_regs
    import lcd_cmd_pkg::*;
#(
    parameter int ADDR_W = 3,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [WORD_W-1:0] reg_wdata,
    output logic [WORD_W-1:0] reg_rdata,
    input  logic              busy,
    input  logic              cap_en,
    input  logic [DATA_W-1:0] cap_data,
    output logic              wr_kick,
    output logic              rd_kick,
    output logic              kick_sel,
    output logic              w_valid,
    output logic              w_rs,
    output logic [DATA_W-1:0] w_data,
    output logic              r_rs
);

    localparam logic [ADDR_W-1:0] A_WDATA = ADDR_W'(OFS_WDATA);
    localparam logic [ADDR_W-1:0] A_WKICK = ADDR_W'(OFS_WKICK);
    localparam logic [ADDR_W-1:0] A_RDATA = ADDR_W'(OFS_RDATA);
    localparam logic [ADDR_W-1:0] A_RKICK = ADDR_W'(OFS_RKICK);
    localparam logic [ADDR_W-1:0] A_STAT  = ADDR_W'(OFS_STAT);

    typedef struct packed {
        logic              w_valid;
        logic              w_rs;
        logic [DATA_W-1:0] w_data;
        logic              r_rs;
        logic [DATA_W-1:0] r_data;
    } regs_t;

    regs_t regs_d, regs_q;
    logic  unused_wbits;

    assign unused_wbits = ^reg_wdata;

    always_comb begin
        regs_d = regs_q;
        if (reg_we && reg_addr == A_WDATA) begin
            regs_d.w_valid = reg_wdata[VALID_BIT];
            regs_d.w_rs    = reg_wdata[RS_BIT];
            regs_d.w_data  = reg_wdata[DATA_W-1:0];
        end
        if (reg_we && reg_addr == A_RDATA) begin
            regs_d.r_rs = reg_wdata[RS_BIT];
        end
        if (cap_en) begin
            regs_d.r_data = cap_data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            regs_q <= '0;
        end else begin
            regs_q <= regs_d;
        end
    end

    assign wr_kick  = reg_we && (reg_addr == A_WKICK) && reg_wdata[GO_BIT];
    assign rd_kick  = reg_we && (reg_addr == A_RKICK) && reg_wdata[GO_BIT];
    assign kick_sel = reg_wdata[SEL_BIT];
    assign w_valid  = regs_q.w_valid;
    assign w_rs     = regs_q.w_rs;
    assign w_data   = regs_q.w_data;
    assign r_rs     = regs_q.r_rs;

    always_comb begin
        reg_rdata = '0;
        unique case (reg_addr)
            A_WDATA: begin
                reg_rdata[VALID_BIT]    = regs_q.w_valid;
                reg_rdata[RS_BIT]       = regs_q.w_rs;
                reg_rdata[DATA_W-1:0]   = regs_q.w_data;
            end
            A_RDATA: reg_rdata[DATA_W-1:0] = regs_q.r_data;
            A_STAT:  reg_rdata[BUSY_BIT]   = busy;
            default: reg_rdata = '0;
        endcase
    end

endmodule

// File: rtl/lcd_cmd_timer.sv
module lcd_cmd_timer #(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             expired
);

    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        if (load) begin
            cnt_d = load_val;
        end else if (cnt_q != '0) begin
            cnt_d = cnt_q - 1'b1;
        end else begin
            cnt_d = cnt_q;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign expired = (cnt_q == '0);

endmodule

// File: rtl/lcd_cmd_seq.sv
module lcd_cmd_seq
    import lcd_cmd_pkg::*;
#(
    parameter int CNT_W  = 4,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_kick,
    input  logic              rd_kick,
    input  logic              kick_sel,
    input  logic              w_valid,
    input  logic              w_rs,
    input  logic [DATA_W-1:0] w_data,
    input  logic              r_rs,
    input  logic [CNT_W-1:0]  cfg_setup,
    input  logic [CNT_W-1:0]  cfg_pulse,
    input  logic [CNT_W-1:0]  cfg_hold,
    input  logic [DATA_W-1:0] pnl_din,
    output logic              busy,
    output logic              cap_en,
    output logic [DATA_W-1:0] cap_data,
    output logic              pnl_cs_main_n,
    output logic              pnl_cs_sub_n,
    output logic              pnl_rs,
    output logic              pnl_wr_n,
    output logic              pnl_rd_n,
    output logic [DATA_W-1:0] pnl_dout,
    output logic              pnl_dout_en
);

    typedef struct packed {
        phase_e            phase;
        logic              sel;
        logic              rs;
        logic              rd;
        logic [DATA_W-1:0] dout;
        logic              cs_main_n;
        logic              cs_sub_n;
        logic              wr_n;
        logic              rd_n;
        logic              dout_en;
    } seq_t;

    seq_t             seq_d, seq_q;
    logic             t_load;
    logic [CNT_W-1:0] t_val;
    logic             t_expired;
    logic             go_wr;
    logic             active_d;

    lcd_cmd_timer #(.CNT_W(CNT_W)) i_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (t_load),
        .load_val (t_val),
        .expired  (t_expired)
    );

    assign go_wr = wr_kick && w_valid;

    always_comb begin
        seq_d  = seq_q;
        t_load = 1'b0;
        t_val  = '0;
        cap_en = 1'b0;
        unique case (seq_q.phase)
            PH_IDLE: begin
                if (go_wr || rd_kick) begin
                    seq_d.phase = PH_SETUP;
                    seq_d.sel   = kick_sel;
                    seq_d.rd    = !go_wr;
                    seq_d.rs    = go_wr ? w_rs : r_rs;
                    if (go_wr) begin
                        seq_d.dout = w_data;
                    end
                    t_load = 1'b1;
                    t_val  = cfg_setup;
                end
            end
            PH_SETUP: begin
                if (t_expired) begin
                    seq_d.phase = PH_PULSE;
                    t_load      = 1'b1;
                    t_val       = cfg_pulse;
                end
            end
            PH_PULSE: begin
                if (t_expired) begin
                    seq_d.phase = PH_HOLD;
                    t_load      = 1'b1;
                    t_val       = cfg_hold;
                    cap_en      = seq_q.rd;
                end
            end
            PH_HOLD: begin
                if (t_expired) begin
                    seq_d.phase = PH_IDLE;
                end
            end
            default: seq_d.phase = PH_IDLE;
        endcase

        active_d        = (seq_d.phase != PH_IDLE);
        seq_d.cs_main_n = !(active_d && !seq_d.sel);
        seq_d.cs_sub_n  = !(active_d && seq_d.sel);
        seq_d.wr_n      = !(seq_d.phase == PH_PULSE && !seq_d.rd);
        seq_d.rd_n      = !(seq_d.phase == PH_PULSE && seq_d.rd);
        seq_d.dout_en   = active_d && !seq_d.rd;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seq_q           <= '0;
            seq_q.phase     <= PH_IDLE;
            seq_q.cs_main_n <= 1'b1;
            seq_q.cs_sub_n  <= 1'b1;
            seq_q.wr_n      <= 1'b1;
            seq_q.rd_n      <= 1'b1;
        end else begin
            seq_q <= seq_d;
        end
    end

    assign busy          = (seq_q.phase != PH_IDLE);
    assign cap_data      = pnl_din;
    assign pnl_cs_main_n = seq_q.cs_main_n;
    assign pnl_cs_sub_n  = seq_q.cs_sub_n;
    assign pnl_rs        = seq_q.rs;
    assign pnl_wr_n      = seq_q.wr_n;
    assign pnl_rd_n      = seq_q.rd_n;
    assign pnl_dout      = seq_q.dout;
    assign pnl_dout_en   = seq_q.dout_en;

endmodule

// File: rtl/lcd_cmd_engine.sv
module lcd_cmd_engine
    import lcd_cmd_pkg::*;
#(
    parameter int ADDR_W = 3,
    parameter int DATA_W = 16,
    parameter int CNT_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    input  logic [CNT_W-1:0]  cfg_setup,
    input  logic [CNT_W-1:0]  cfg_pulse,
    input  logic [CNT_W-1:0]  cfg_hold,
    output logic              pnl_cs_main_n,
    output logic              pnl_cs_sub_n,
    output logic              pnl_rs,
    output logic              pnl_wr_n,
    output logic              pnl_rd_n,
    output logic [DATA_W-1:0] pnl_dout,
    output logic              pnl_dout_en,
    input  logic [DATA_W-1:0] pnl_din
);

    logic              busy;
    logic              cap_en;
    logic [DATA_W-1:0] cap_data;
    logic              wr_kick;
    logic              rd_kick;
    logic              kick_sel;
    logic              w_valid;
    logic              w_rs;
    logic [DATA_W-1:0] w_data;
    logic              r_rs;

    lcd_cmd_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_we    (reg_we),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .busy      (busy),
        .cap_en    (cap_en),
        .cap_data  (cap_data),
        .wr_kick   (wr_kick),
        .rd_kick   (rd_kick),
        .kick_sel  (kick_sel),
        .w_valid   (w_valid),
        .w_rs      (w_rs),
        .w_data    (w_data),
        .r_rs      (r_rs)
    );

    lcd_cmd_seq #(.CNT_W(CNT_W), .DATA_W(DATA_W)) i_seq (
        .clk           (clk),
        .rst_n         (rst_n),
        .wr_kick       (wr_kick),
        .rd_kick       (rd_kick),
        .kick_sel      (kick_sel),
        .w_valid       (w_valid),
        .w_rs          (w_rs),
        .w_data        (w_data),
        .r_rs          (r_rs),
        .cfg_setup     (cfg_setup),
        .cfg_pulse     (cfg_pulse),
        .cfg_hold      (cfg_hold),
        .pnl_din       (pnl_din),
        .busy          (busy),
        .cap_en        (cap_en),
        .cap_data      (cap_data),
        .pnl_cs_main_n (pnl_cs_main_n),
        .pnl_cs_sub_n  (pnl_cs_sub_n),
        .pnl_rs        (pnl_rs),
        .pnl_wr_n      (pnl_wr_n),
        .pnl_rd_n      (pnl_rd_n),
        .pnl_dout      (pnl_dout),
        .pnl_dout_en   (pnl_dout_en)
    );

endmodule

// File: rtl/lcd_cmd_chk.sv
module lcd_cmd_chk
    import lcd_cmd_pkg::*;
#(
    parameter int ADDR_W = 3,
    parameter int DATA_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              reg_we,
    input logic [ADDR_W-1:0] reg_addr,
    input logic              pnl_cs_main_n,
    input logic              pnl_cs_sub_n,
    input logic              pnl_rs,
    input logic              pnl_wr_n,
    input logic              pnl_rd_n,
    input logic [DATA_W-1:0] pnl_dout,
    input logic              pnl_dout_en
);

    logic cs_low;
    assign cs_low = !pnl_cs_main_n || !pnl_cs_sub_n;

    // R6
    one_cs_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({!pnl_cs_main_n, !pnl_cs_sub_n}));

    // R10
    strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(!pnl_wr_n && !pnl_rd_n));

    // R10
    strobe_in_cs_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!pnl_wr_n || !pnl_rd_n) |-> cs_low);

    // R5
    setup_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(pnl_wr_n) || $fell(pnl_rd_n)) |-> $past(cs_low));

    // R2
    start_on_kick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cs_low) |-> $past(reg_we && (reg_addr == ADDR_W'(OFS_WKICK)
                                        || reg_addr == ADDR_W'(OFS_RKICK))));

    // R9
    steady_xfer_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_low && $past(cs_low)) |-> ($stable(pnl_rs) && $stable(pnl_dout)
                                       && $stable(pnl_cs_sub_n)));

    // R7
    read_no_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !pnl_rd_n |-> !pnl_dout_en);

endmodule

bind lcd_cmd_engine lcd_cmd_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_chk (.*);

// File: tb/test_lcd_cmd_engine.sv
`timescale 1ns/1ps
module test_lcd_cmd_engine;
    import lcd_cmd_pkg::*;

    localparam int ADDR_W = 3;
    localparam int DATA_W = 16;
    localparam int CNT_W  = 4;

    logic              clk = 1'b0;
    logic              rst_n;
    logic              reg_we;
    logic [ADDR_W-1:0] reg_addr;
    logic [31:0]       reg_wdata;
    logic [31:0]       reg_rdata;
    logic [CNT_W-1:0]  cfg_setup, cfg_pulse, cfg_hold;
    logic              pnl_cs_main_n, pnl_cs_sub_n, pnl_rs, pnl_wr_n, pnl_rd_n;
    logic [DATA_W-1:0] pnl_dout;
    logic              pnl_dout_en;
    logic [DATA_W-1:0] pnl_din;
    logic [DATA_W-1:0] din_base;

    always #4 clk = ~clk;

    lcd_cmd_engine #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W)) i_lcd_cmd_engine (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .cfg_setup(cfg_setup), .cfg_pulse(cfg_pulse), .cfg_hold(cfg_hold),
        .pnl_cs_main_n(pnl_cs_main_n), .pnl_cs_sub_n(pnl_cs_sub_n),
        .pnl_rs(pnl_rs), .pnl_wr_n(pnl_wr_n), .pnl_rd_n(pnl_rd_n),
        .pnl_dout(pnl_dout), .pnl_dout_en(pnl_dout_en), .pnl_din(pnl_din)
    );

    typedef struct {
        bit          rd;
        bit          sel;
        bit          rs;
        logic [15:0] data;
        int          setup;
        int          pulse;
        int          hold;
    } exp_t;

    exp_t sb_q[$];
    int   checks = 0;
    int   fails  = 0;
    int   overlap_cnt = 0;

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // monitor state
    bit          in_x = 0;
    int          setup_c, pulse_c, hold_c;
    bit          o_sel, o_rs, o_rd, o_oe, o_glitch;
    logic [15:0] o_dout;
    bit          cs_l;
    exp_t        e;

    always @(negedge clk) begin
        cs_l = !pnl_cs_main_n || !pnl_cs_sub_n;
        if (!rst_n) begin
            in_x    = 0;
            pnl_din = din_base;
        end else begin
            if ((!pnl_wr_n && !pnl_rd_n) || ((!pnl_wr_n || !pnl_rd_n) && !cs_l))
                overlap_cnt++;
            if (cs_l) begin
                if (!in_x) begin
                    in_x = 1; setup_c = 0; pulse_c = 0; hold_c = 0;
                    o_sel = !pnl_cs_sub_n; o_rs = pnl_rs; o_rd = 0;
                    o_dout = 16'h0; o_oe = 0; o_glitch = 0;
                end
                if (pnl_rs != o_rs || o_sel != !pnl_cs_sub_n) o_glitch = 1;
                if (!pnl_wr_n || !pnl_rd_n) begin
                    pulse_c++;
                    o_oe = pnl_dout_en;
                    if (!pnl_rd_n) o_rd = 1;
                    else o_dout = pnl_dout;
                end else if (pulse_c == 0) begin
                    setup_c++;
                end else begin
                    hold_c++;
                end
            end else if (in_x) begin
                in_x = 0;
                if (sb_q.size() == 0) begin
                    chk(0, "R3", "unexpected transfer", 1, 0);
                end else begin
                    e = sb_q.pop_front();
                    chk(o_rd == e.rd, "R7", "direction", o_rd, e.rd);
                    chk(setup_c == e.setup, "R5", "setup cycles", setup_c, e.setup);
                    chk(pulse_c == e.pulse, "R5", "strobe cycles", pulse_c, e.pulse);
                    chk(hold_c == e.hold, "R5", "hold cycles", hold_c, e.hold);
                    chk(o_sel == e.sel, "R6", "panel select", o_sel, e.sel);
                    chk(o_rs == e.rs, "R4", "rs level", o_rs, e.rs);
                    chk(o_oe == !e.rd, "R4", "output enable", o_oe, !e.rd);
                    if (!e.rd) chk(o_dout == e.data, "R4", "data bus", o_dout, e.data);
                    chk(!o_glitch, "R9", "rs/select changed mid transfer", o_glitch, 0);
                end
            end
            if (!pnl_rd_n) pnl_din = din_base + 16'(pulse_c);
            else pnl_din = din_base;
        end
    end

    task automatic reg_write(input logic [ADDR_W-1:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic run_xfer(input bit rd, input bit sel, input bit rs, input bit valid,
                            input bit extra, input logic [15:0] data,
                            input int s, input int p, input int h, input string tag);
        int   n;
        int   exp_n;
        exp_t it;
        logic [ADDR_W-1:0] kaddr;
        @(negedge clk);
        cfg_setup = CNT_W'(s); cfg_pulse = CNT_W'(p); cfg_hold = CNT_W'(h);
        if (!rd) reg_write(ADDR_W'(OFS_WDATA), (32'(valid) << 28) | (32'(rs) << 24) | 32'(data));
        else     reg_write(ADDR_W'(OFS_RDATA), 32'(rs) << 24);
        kaddr = rd ? ADDR_W'(OFS_RKICK) : ADDR_W'(OFS_WKICK);
        if (valid || rd) begin
            it.rd = rd; it.sel = sel; it.rs = rs; it.data = data;
            it.setup = s + 1; it.pulse = p + 1; it.hold = h + 1;
            sb_q.push_back(it);
        end
        @(negedge clk);
        reg_we = 1'b1; reg_addr = kaddr; reg_wdata = {30'd0, sel, 1'b1};
        n = 0;
        forever begin
            @(negedge clk);
            if (extra && n == 1) begin
                reg_we = 1'b1; reg_addr = kaddr; reg_wdata = {30'd0, !sel, 1'b1};
                n++;
            end else begin
                reg_we = 1'b0; reg_addr = ADDR_W'(OFS_STAT);
                #1;
                if (!reg_rdata[1] || n > 1000) break;
                n++;
            end
        end
        exp_n = (valid || rd) ? (s + p + h + 3) : 0;
        chk(n == exp_n, tag, "busy cycles", n, exp_n);
        if (rd) begin
            reg_addr = ADDR_W'(OFS_RDATA);
            #1;
            chk(reg_rdata == {16'd0, din_base + 16'(p + 1)}, "R8", "read capture",
                reg_rdata, {16'd0, din_base + 16'(p + 1)});
        end
        repeat (2) @(negedge clk);
    endtask

    task automatic report();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        report();
    end

    initial begin
        rst_n = 1'b0; reg_we = 1'b0; reg_addr = '0; reg_wdata = '0;
        cfg_setup = '0; cfg_pulse = '0; cfg_hold = '0; din_base = 16'h0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        chk(pnl_cs_main_n && pnl_cs_sub_n, "R1", "chip selects",
            {pnl_cs_main_n, pnl_cs_sub_n}, 2'b11);
        chk(pnl_wr_n && pnl_rd_n, "R1", "strobes", {pnl_wr_n, pnl_rd_n}, 2'b11);
        reg_addr = ADDR_W'(OFS_STAT); #1;
        chk(reg_rdata[1] == 1'b0, "R1", "busy", reg_rdata[1], 0);
        reg_addr = ADDR_W'(OFS_RDATA); #1;
        chk(reg_rdata == 32'd0, "R1", "read data", reg_rdata, 0);

        run_xfer(0, 0, 0, 1, 0, 16'h00A5, 0, 0, 0, "R2");
        run_xfer(0, 1, 1, 1, 0, 16'h5A3C, 2, 3, 1, "R6");
        run_xfer(0, 0, 1, 0, 0, 16'h1111, 1, 1, 1, "R3");
        din_base = 16'h1230;
        run_xfer(1, 0, 1, 1, 0, 16'h0, 1, 2, 2, "R7");
        run_xfer(0, 0, 1, 1, 1, 16'hC0DE, 1, 1, 1, "R9");
        din_base = 16'hBEE0;
        run_xfer(1, 1, 0, 1, 1, 16'h0, 0, 4, 0, "R9");
        run_xfer(0, 1, 0, 1, 0, 16'hFFFF, 3, 0, 2, "R5");

        chk(sb_q.size() == 0, "R2", "transfers left unseen", sb_q.size(), 0);
        chk(overlap_cnt == 0, "R10", "strobe overlap or strobe without select",
            overlap_cnt, 0);
        report();
    end

endmodule